// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Bank

This block is a pulse-width modulator with several output channels. All channels share a single time base. Software programs the block through a plain 32-bit register port made of an address, a write strobe, write data and combinational read data. The port holds a control word, an interrupt-enable word and one duty word for each channel.

An 8-bit prescale value turns the input clock into a slower tick, and an 8-bit counter advances once per tick. Every channel's period is therefore 256 ticks. Changing the prescale value is the only way to change the period. Each channel drives its output high while the counter is at or below that channel's duty value.

A small two-state machine controls the time base. In state IDLE the prescaler and the counter sit at zero and all outputs are low. The START transition moves IDLE to RUN on the first clock edge that sees the enable bit set. The STOP transition moves RUN back to IDLE on the first clock edge that sees the enable bit clear. While the block is in RUN, new duty and prescale values wait in their registers. They are copied into the active copies only at the edge where the counter wraps from 255 to 0. While the block is in IDLE, the active copies follow the registers on every cycle.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads zero, every PWM output is low and the interrupt-enable output is low.
- R2: The control word is at address 0x50. Prescale bits [3:0] are control bits [3:0], prescale bits [7:4] are control bits [14:11], and bit 9 is the global enable. All other control bits read as zero.
- R3: The duty word of channel i is at address 4*i and keeps bits [7:0]. Its upper bits read as zero. A write to channel i changes no other channel. An address that maps to no register reads as zero.
- R4: While the enable bit is clear, all outputs are low and the time base is held at zero. After a write that clears the enable bit, the outputs are low from the second cycle after the write edge onward.
- R5: A duty value N gives a high time of N+1 ticks at the start of each 256-tick period. The output is low for the remaining ticks of the period.
- R6: A duty value of 0 gives a pulse one tick long. A duty value of 255 keeps the output high through the whole period.
- R7: One tick lasts (prescale + 1) input clocks, so one period lasts 256*(prescale+1) clocks.
- R8: A duty value written while the block is running takes effect only at the next wrap from 255 to 0.
- R9: A prescale value written while the block is running takes effect only at the next wrap from 255 to 0.
- R10: Setting the enable bit starts every channel together, at tick 0, in the second cycle after the write edge.
- R11: Bit 0 of the word at address 0x54 is the interrupt enable. It reads back, its other bits read as zero, and it drives the interrupt-enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_en_o | output | 1 | Stored interrupt-enable bit |
| pwm_o | output | NUM_CH | One PWM output per channel |

## Verification
Read data is combinational, so the bench checks it in the same cycle it sets the address. A register write becomes visible one edge after the strobe. The START and STOP transitions take effect one edge after that. Tick 0 of the first period therefore falls in the second cycle after the enable write, and a stopped output is low from the second cycle after the disabling write. For each stimulus, the driver works out the exact cycle of each expected output from tick k, which falls at (start + k*(prescale+1)). It queues that cycle with the expected vector, and the monitor compares the outputs at the falling edge of exactly that cycle. This places staged-update checks on both sides of the wrap edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int DATA_W    = 32;
    localparam int PS_W      = 8;
    localparam int CNT_W     = 8;
    localparam int CTRL_OFS  = 'h50;
    localparam int INTEN_OFS = 'h54;
    localparam int EN_BIT    = 9;
    localparam int PS_LO_LSB = 0;
    localparam int PS_HI_LSB = 11;
    localparam int NIB       = PS_W / 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tb_state_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 1,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      we_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic [NUM_CH*CNT_W-1:0]   duty_flat_o,
    output logic [PS_W-1:0]           prescale_o,
    output logic                      enable_o,
    output logic                      irq_en_o
);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] INTEN_A = ADDR_W'(INTEN_OFS);

    logic [PS_W-1:0]  ps_q;
    logic             en_q;
    logic             inten_q;
    logic [CNT_W-1:0] duty_q [NUM_CH];
    logic             unused_bits;

    assign unused_bits = ^{wdata_i[DATA_W-1:PS_HI_LSB+NIB], wdata_i[PS_HI_LSB-1:EN_BIT+1],
                           wdata_i[EN_BIT-1:CNT_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q    <= '0;
            en_q    <= 1'b0;
            inten_q <= 1'b0;
        end else if (we_i) begin
            if (addr_i == CTRL_A) begin
                ps_q[NIB-1:0]    <= wdata_i[PS_LO_LSB +: NIB];
                ps_q[PS_W-1:NIB] <= wdata_i[PS_HI_LSB +: NIB];
                en_q             <= wdata_i[EN_BIT];
            end
            if (addr_i == INTEN_A) begin
                inten_q <= wdata_i[0];
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_duty
        localparam logic [ADDR_W-1:0] DUTY_A = ADDR_W'(4 * g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                duty_q[g] <= '0;
            end else if (we_i && addr_i == DUTY_A) begin
                duty_q[g] <= wdata_i[CNT_W-1:0];
            end
        end
        assign duty_flat_o[g*CNT_W +: CNT_W] = duty_q[g];
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_A) begin
            rdata_o[PS_LO_LSB +: NIB] = ps_q[NIB-1:0];
            rdata_o[PS_HI_LSB +: NIB] = ps_q[PS_W-1:NIB];
            rdata_o[EN_BIT]           = en_q;
        end else if (addr_i == INTEN_A) begin
            rdata_o[0] = inten_q;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr_i == ADDR_W'(4 * i)) begin
                rdata_o[CNT_W-1:0] = duty_q[i];
            end
        end
    end

    assign prescale_o = ps_q;
    assign enable_o   = en_q;
    assign irq_en_o   = inten_q;

    // R2: the enable seen by the time base follows a control write one edge later
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == CTRL_A) |=> (enable_o == $past(wdata_i[EN_BIT])));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [PS_W-1:0]  prescale_i,
    output logic             run_o,
    output logic             load_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    tb_state_e        state_q, state_d;
    logic [PS_W-1:0]  psc_q, ps_act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick, wrap, advance;

    // next-state logic: START (IDLE->RUN) and STOP (RUN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable_i)  state_d = ST_RUN;
            ST_RUN:  if (!enable_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign tick    = (state_q == ST_RUN) && (psc_q == ps_act_q);
    assign wrap    = tick && (cnt_q == CNT_LAST);
    assign advance = (state_q == ST_RUN) && (state_d == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
            cnt_q <= '0;
        end else if (!advance) begin
            psc_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            psc_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            psc_q <= psc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ps_act_q <= '0;
        else if (load_o) ps_act_q <= prescale_i;
    end

    // output process
    always_comb begin
        run_o  = (state_q == ST_RUN);
        load_o = (state_q == ST_IDLE) || wrap;
        cnt_o  = cnt_q;
    end

    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (cnt_q == '0 && psc_q == '0));
    assert_ps_staged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !wrap) |=> $stable(ps_act_q));
    assert_tick_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        psc_q <= ps_act_q);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pwm_o
);
    logic [CNT_W-1:0] duty_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      duty_act_q <= '0;
        else if (load_i) duty_act_q <= duty_i;
    end

    always_comb begin
        pwm_o = run_i && (cnt_i <= duty_act_q);
    end

    assert_off_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !pwm_o);
    assert_min_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_i == '0) |-> pwm_o);
    assert_duty_staged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(duty_act_q));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 1,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_en_o,
    output logic [NUM_CH-1:0] pwm_o
);
    logic [NUM_CH*CNT_W-1:0] duty_flat;
    logic [PS_W-1:0]         prescale;
    logic                    enable;
    logic                    run;
    logic                    load;
    logic [CNT_W-1:0]        cnt;

    pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (bus_addr),
        .we_i        (bus_we),
        .wdata_i     (bus_wdata),
        .rdata_o     (bus_rdata),
        .duty_flat_o (duty_flat),
        .prescale_o  (prescale),
        .enable_o    (enable),
        .irq_en_o    (irq_en_o)
    );

    pwm_timebase u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable),
        .prescale_i (prescale),
        .run_o      (run),
        .load_o     (load),
        .cnt_o      (cnt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .run_i  (run),
            .cnt_i  (cnt),
            .duty_i (duty_flat[g*CNT_W +: CNT_W]),
            .pwm_o  (pwm_o[g])
        );
    end
endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
    localparam int NCH = 3;
    localparam logic [7:0] A_CTRL  = 8'h50;
    localparam logic [7:0] A_INTEN = 8'h54;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [7:0]      bus_addr;
    logic            bus_we;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic            irq_en_o;
    logic [NCH-1:0]  pwm_o;

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en_o(irq_en_o), .pwm_o(pwm_o)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          at;
        int          kind;   // 0 outputs, 1 read data, 2 irq enable
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic push(input int at, input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.at = at; it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares every queued item in its own cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at <= cyc) begin
                logic [31:0] act;
                act = (sb[i].kind == 0) ? {29'b0, pwm_o} :
                      (sb[i].kind == 1) ? bus_rdata : {31'b0, irq_en_o};
                checks++;
                if (sb[i].at < cyc) begin
                    errors++;
                    $display("FAIL %s: item for cycle %0d missed (actual %h expected %h)",
                             sb[i].tag, sb[i].at, act, sb[i].exp);
                end else if (act !== sb[i].exp) begin
                    errors++;
                    $display("FAIL %s at cycle %0d kind %0d: actual %h expected %h",
                             sb[i].tag, cyc, sb[i].kind, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        push(cyc, 1, e, tag);
        step();
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) step();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int t0, p, t1, ps1;
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1: reset state
        push(cyc, 0, 32'h0, "R1");
        push(cyc, 2, 32'h0, "R1");
        rd(A_CTRL, 32'h0, "R1");
        rd(A_INTEN, 32'h0, "R1");
        rd(8'h00, 32'h0, "R1");
        rd(8'h08, 32'h0, "R1");

        // R2/R3/R11: field positions and readback
        wr(A_CTRL, 32'hFFFF_FDFF);
        rd(A_CTRL, 32'h0000_780F, "R2");
        wr(A_INTEN, 32'hFFFF_FFFF);
        push(cyc, 2, 32'h1, "R11");
        rd(A_INTEN, 32'h1, "R11");
        wr(8'h04, 32'h1234_56AB);
        rd(8'h04, 32'h0000_00AB, "R3");
        rd(8'h00, 32'h0, "R3");
        rd(8'h08, 32'h0, "R3");
        rd(8'h0C, 32'h0, "R3");
        rd(8'h58, 32'h0, "R3");
        rd(8'h51, 32'h0, "R3");
        push(cyc, 0, 32'h0, "R4");
        step();

        // R5/R6/R10: prescale 0, duties 0 / 100 / 255
        wr(A_CTRL, 32'h0);
        wr(8'h00, 32'd0);
        wr(8'h04, 32'd100);
        wr(8'h08, 32'd255);
        wr(A_CTRL, 32'h200);
        t0 = cyc + 1;
        push(cyc,      0, 32'b000, "R4");
        push(t0,       0, 32'b111, "R10");
        push(t0 + 1,   0, 32'b110, "R6");
        push(t0 + 100, 0, 32'b110, "R5");
        push(t0 + 101, 0, 32'b100, "R5");
        push(t0 + 255, 0, 32'b100, "R6");
        push(t0 + 256, 0, 32'b111, "R5");

        // R8: duty change mid-period waits for the wrap
        wait_until(t0 + 256 + 20);
        wr(8'h04, 32'd10);
        push(t0 + 256 + 50, 0, 32'b110, "R8");
        push(t0 + 512 + 10, 0, 32'b110, "R8");
        push(t0 + 512 + 11, 0, 32'b100, "R8");
        push(t0 + 512 + 50, 0, 32'b100, "R8");

        // R7/R9: prescale 0x12 (low nibble 2, high nibble 1) staged to the wrap
        wait_until(t0 + 512 + 30);
        wr(A_CTRL, 32'h0000_0A02);
        p   = t0 + 768;
        ps1 = 19;
        push(t0 + 512 + 200, 0, 32'b100, "R9");
        push(p - 1,          0, 32'b100, "R9");
        push(p,              0, 32'b111, "R9");
        push(p + ps1 - 1,    0, 32'b111, "R7");
        push(p + ps1,        0, 32'b110, "R7");
        push(p + 11*ps1 - 1, 0, 32'b110, "R7");
        push(p + 11*ps1,     0, 32'b100, "R7");
        push(p + 256*ps1 - 1, 0, 32'b100, "R7");
        push(p + 256*ps1,    0, 32'b111, "R9");
        wait_until(p + 256*ps1 + 5);

        // R4: disable stops everything
        wr(A_CTRL, 32'h0);
        push(cyc + 1,  0, 32'b000, "R4");
        push(cyc + 2,  0, 32'b000, "R4");
        push(cyc + 40, 0, 32'b000, "R4");
        wait_until(cyc + 45);

        // R10/R5: restart aligned at tick 0 with prescale 0
        wr(A_CTRL, 32'h200);
        t1 = cyc + 1;
        push(t1,      0, 32'b111, "R10");
        push(t1 + 1,  0, 32'b110, "R10");
        push(t1 + 10, 0, 32'b110, "R5");
        push(t1 + 11, 0, 32'b100, "R5");
        wait_until(t1 + 20);

        done = 1;
        summary();
    end
endmodule